// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches the read and write accesses on an SRAM bus. It recognises one fixed run of six reads as a software command. The first five reads are the same for both commands. The sixth read picks which command is meant: a store (copy the SRAM into nonvolatile storage) or a recall (copy it back). When it sees a complete run, the block sends a single-cycle pulse to the store/recall sequencer. The reads that make up the run are not blocked: they finish on the bus as usual, and the block only observes them.

A write or an unexpected read in the middle of a run cancels the run. A cancelling read at the first key address is kept as step one of a new run. While the sequencer reports that it is busy, the detector stays idle and ignores the bus. Only the low 16 bits of the address take part in the matching, so the block works on wider address buses.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reset, `storeCmd` and `recallCmd` are low and the detector is idle, with no steps matched.
- R2: Five reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read at 0x8FC0 give a `storeCmd` pulse. The pulse is high in the clock cycle after the edge that samples the sixth read.
- R3: The same five-read prefix followed by a read at 0x4C63 gives a `recallCmd` pulse, with the same timing as in R2.
- R4: A read whose address is not the expected next key cancels the run, and no command is issued for that run.
- R5: A write access (`accWrite`=1) cancels the run at any step, even when its address is the expected key.
- R6: A read at 0x4E38 that cancels a run is taken as step one of a new run. Any other cancelling access returns the detector to idle.
- R7: A cycle with `accValid` low is not an access. It neither advances nor cancels a run. One strobe covers both chip-enable-timed and output-enable-timed reads.
- R8: Address bits at position 16 and above are ignored by the matching.
- R9: In every cycle where `seqBusy` is high, all accesses are ignored and the detector returns to idle, so a run in progress is lost.
- R10: Each command pulse lasts one cycle, and `storeCmd` and `recallCmd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | One bus access is sampled in this cycle |
| accWrite | input | 1 | 1 = the access is a write, 0 = the access is a read |
| accAddr | input | ADDR_W | Access address (ADDR_W >= 16) |
| seqBusy | input | 1 | The store/recall sequencer is busy executing a command |
| storeCmd | output | 1 | One-cycle store command pulse |
| recallCmd | output | 1 | One-cycle recall command pulse |

## Verification
Both command outputs are registered once. A pulse is therefore due exactly one cycle after the rising edge that samples the sixth read, and it must be gone one cycle later. The bench drives each access on a falling edge and advances its reference model at the next rising edge. It then compares both outputs on the following falling edge. In this way every result is checked in the single cycle where it is due. The checks cover both pulses, and they also confirm that no pulse appears in any other cycle: after cancelled runs, during busy windows, and in the cycles that follow a completed command.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int KEY_W      = 16;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [KEY_W-1:0] STORE_KEY  = 16'h8FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 16'h4C63;

  // Ordered prefix keys; order is behaviour.
  function automatic logic [KEY_W-1:0] prefixKey(input int idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      default: return 16'h703F;
    endcase
  endfunction

  typedef struct packed {
    logic store;
    logic recall;
  } cmdStrobe_t;
endpackage

// File: rtl/cmd_seq_match.sv
module cmd_seq_match
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     accAddr,
  input  cmdStrobe_t            cmdStrobe,
  output logic [PREFIX_LEN-1:0] prefixHit,
  output logic                  storeHit,
  output logic                  recallHit,
  output logic                  storeCmd,
  output logic                  recallCmd
);
  logic [KEY_W-1:0] addrLo;
  assign addrLo = accAddr[KEY_W-1:0];

  for (genvar k = 0; k < PREFIX_LEN; k++) begin : g_prefix
    assign prefixHit[k] = (addrLo == prefixKey(k));
  end

  assign storeHit  = (addrLo == STORE_KEY);
  assign recallHit = (addrLo == RECALL_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storeCmd  <= 1'b0;
      recallCmd <= 1'b0;
    end else begin
      storeCmd  <= cmdStrobe.store;
      recallCmd <= cmdStrobe.recall;
    end
  end

  initial begin
    addr_width_chk: assert (ADDR_W >= KEY_W);
  end

  // R10
  no_dual_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeCmd && recallCmd));
  // R10
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeCmd |=> !storeCmd);
  // R10
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallCmd |=> !recallCmd);
  // R8
  store_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    !storeHit |=> !storeCmd);
  // R8
  recall_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    !recallHit |=> !recallCmd);
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic                  seqBusy,
  input  logic [PREFIX_LEN-1:0] prefixHit,
  input  logic                  storeHit,
  input  logic                  recallHit,
  output cmdStrobe_t            cmdStrobe
);
  logic [STEP_W-1:0] stepQ, stepD;
  logic              readAcc;
  logic              expectHit;
  logic [STEP_W-1:0] restartStep;

  assign readAcc     = accValid && !accWrite;
  assign restartStep = prefixHit[0] ? STEP_W'(1) : '0;
  assign expectHit   = (stepQ < STEP_W'(PREFIX_LEN)) ?
                       prefixHit[stepQ[$clog2(PREFIX_LEN)-1:0]] : 1'b0;

  always_comb begin
    stepD     = stepQ;
    cmdStrobe = '0;
    if (seqBusy) begin
      stepD = '0;
    end else if (accValid && accWrite) begin
      stepD = '0;
    end else if (readAcc) begin
      if (stepQ == STEP_W'(PREFIX_LEN)) begin
        if (storeHit) begin
          cmdStrobe.store = 1'b1;
          stepD = '0;
        end else if (recallHit) begin
          cmdStrobe.recall = 1'b1;
          stepD = '0;
        end else begin
          stepD = restartStep;
        end
      end else if (expectHit) begin
        stepD = stepQ + STEP_W'(1);
      end else begin
        stepD = restartStep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepQ <= '0;
    else       stepQ <= stepD;
  end

  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |=> (stepQ == '0));
  // R5
  write_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> (stepQ == '0));
  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && !seqBusy) |=> $stable(stepQ));
  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepQ <= STEP_W'(PREFIX_LEN));
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              seqBusy,
  output logic              storeCmd,
  output logic              recallCmd
);
  cmdStrobe_t            cmdStrobe;
  logic [PREFIX_LEN-1:0] prefixHit;
  logic                  storeHit;
  logic                  recallHit;

  cmd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .seqBusy   (seqBusy),
    .prefixHit (prefixHit),
    .storeHit  (storeHit),
    .recallHit (recallHit),
    .cmdStrobe (cmdStrobe)
  );

  cmd_seq_match #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rstN      (rstN),
    .accAddr   (accAddr),
    .cmdStrobe (cmdStrobe),
    .prefixHit (prefixHit),
    .storeHit  (storeHit),
    .recallHit (recallHit),
    .storeCmd  (storeCmd),
    .recallCmd (recallCmd)
  );

  // R9
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |=> !(storeCmd || recallCmd));
  // R5
  write_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite) |=> !(storeCmd || recallCmd));
  // R7
  idle_no_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !(storeCmd || recallCmd));
endmodule

// File: tb/tb_cmd_seq_detect.sv
module tb_cmd_seq_detect;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN;
  logic              accValid, accWrite, seqBusy;
  logic [ADDR_W-1:0] accAddr;
  logic              storeCmd, recallCmd;

  int nChecks = 0;
  int nFails  = 0;
  int mStep   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cmd_seq_detect #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .seqBusy(seqBusy),
    .storeCmd(storeCmd), .recallCmd(recallCmd)
  );

  function automatic logic [15:0] keyAt(int i);
    case (i)
      0: return 16'h4E38;
      1: return 16'hB1C7;
      2: return 16'h83E0;
      3: return 16'h7C1F;
      4: return 16'h703F;
      5: return 16'h8FC0;
      default: return 16'h4C63;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mkAddr(logic [15:0] lo, logic [ADDR_W-17:0] hi);
    return {hi, lo};
  endfunction

  // Reference: returns {store, recall} due next cycle, updates mStep.
  function automatic logic [1:0] model(logic v, logic w, logic [ADDR_W-1:0] a, logic b);
    logic [15:0] lo = a[15:0];
    logic [1:0]  res = 2'b00;
    int          restart = (lo == keyAt(0)) ? 1 : 0;
    if (b) mStep = 0;
    else if (v && w) mStep = 0;
    else if (v) begin
      if (mStep == 5) begin
        if (lo == keyAt(5)) begin res = 2'b10; mStep = 0; end
        else if (lo == keyAt(6)) begin res = 2'b01; mStep = 0; end
        else mStep = restart;
      end else if (lo == keyAt(mStep)) mStep = mStep + 1;
      else mStep = restart;
    end
    return res;
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    nChecks++;
    if ({storeCmd, recallCmd} !== exp) begin
      nFails++;
      $display("FAIL %s: store/recall=%b%b expected %b%b", tag,
               storeCmd, recallCmd, exp[1], exp[0]);
    end
  endtask

  task automatic cyc(string tag, logic v, logic w, logic [ADDR_W-1:0] a, logic b);
    logic [1:0] exp;
    accValid = v; accWrite = w; accAddr = a; seqBusy = b;
    @(posedge clk);
    exp = model(v, w, a, b);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic rd(string tag, logic [15:0] lo);
    cyc(tag, 1'b1, 1'b0, mkAddr(lo, '0), 1'b0);
  endtask

  task automatic prefix(string tag);
    for (int i = 0; i < 5; i++) rd(tag, keyAt(i));
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0; accAddr = '0; seqBusy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 2'b00);
    rstN = 1'b1;
    mStep = 0;
    idle("R1 idle", 2);

    // R2 store
    prefix("R2"); rd("R2 store", 16'h8FC0); idle("R10 after store", 2);
    // R3 recall
    prefix("R3"); rd("R3 recall", 16'h4C63); idle("R10 after recall", 2);
    // R4 mismatching read mid-run
    rd("R4", keyAt(0)); rd("R4", keyAt(1)); rd("R4 bad", 16'h1234);
    rd("R4", keyAt(3)); rd("R4", keyAt(4)); rd("R4 no cmd", 16'h8FC0);
    // R4 wrong sixth read
    prefix("R4"); rd("R4 bad sixth", 16'h0000); rd("R4 late store", 16'h8FC0);
    // R5 write at expected key
    rd("R5", keyAt(0)); rd("R5", keyAt(1));
    cyc("R5 write", 1'b1, 1'b1, mkAddr(keyAt(2), '0), 1'b0);
    rd("R5", keyAt(3)); rd("R5", keyAt(4)); rd("R5 no cmd", 16'h4C63);
    prefix("R5"); cyc("R5 write sixth", 1'b1, 1'b1, mkAddr(16'h8FC0, '0), 1'b0);
    idle("R5", 1);
    // R6 aborting read at first key restarts
    rd("R6", keyAt(0)); rd("R6", keyAt(1)); rd("R6", keyAt(2));
    rd("R6 restart", keyAt(0));
    for (int i = 1; i < 5; i++) rd("R6", keyAt(i));
    rd("R6 store", 16'h8FC0);
    prefix("R6"); rd("R6 sixth restart", keyAt(0));
    for (int i = 1; i < 5; i++) rd("R6", keyAt(i));
    rd("R6 recall", 16'h4C63);
    // R7 gaps between steps
    for (int i = 0; i < 5; i++) begin rd("R7", keyAt(i)); idle("R7 gap", i + 1); end
    rd("R7 store", 16'h8FC0);
    // R8 upper bits ignored
    for (int i = 0; i < 5; i++)
      cyc("R8", 1'b1, 1'b0, mkAddr(keyAt(i), 4'(i + 9)), 1'b0);
    cyc("R8 recall", 1'b1, 1'b0, mkAddr(16'h4C63, 4'hF), 1'b0);
    // R9 busy clears progress and masks accesses
    rd("R9", keyAt(0)); rd("R9", keyAt(1));
    cyc("R9 busy", 1'b1, 1'b0, mkAddr(keyAt(2), '0), 1'b1);
    rd("R9", keyAt(3)); rd("R9", keyAt(4)); rd("R9 no cmd", 16'h8FC0);
    prefix("R9");
    cyc("R9 busy sixth", 1'b1, 1'b0, mkAddr(16'h8FC0, '0), 1'b1);
    idle("R9", 1);

    // R10 random mix, biased toward the expected next key
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(99));
      logic [15:0] lo;
      if (r < 60) lo = (mStep == 5) ? keyAt(5 + int'($urandom_range(1))) : keyAt(mStep);
      else if (r < 75) lo = keyAt(0);
      else lo = 16'($urandom);
      cyc("R10 random", ($urandom_range(99) < 75), ($urandom_range(99) < 6),
          mkAddr(lo, 4'($urandom)), ($urandom_range(99) < 3));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule